// File: doc/BRIEF.md
# Resolver Position/Velocity Sample-and-Readout Port

This block sits between a resolver-to-digital tracking loop and a host. The loop has two integrators that never stop: an absolute shaft angle and a signed shaft speed. When the host drops a sample strobe, the block freezes both integrator words together into a pair of holding registers. The integrators keep running while the host reads.

The host reads one held word per access. With chip select low, it picks angle or speed with a select line and drops a read strobe. In parallel mode the chosen word appears on a 12-bit bus. In serial mode the top bus pin becomes a data output and the pin below it becomes a clock input, and the word leaves MSB first.

The block also tracks the smallest and largest magnitude seen on a monitor input. These extremes are cleared on the rising edge of the sample strobe. All host strobes are asynchronous. Each one passes through a two-flop synchroniser before use.

Top module: `resolver_readout`

## Requirements
- R1: While reset is asserted, no bus pin is enabled, the monitor minimum reads 0xFFF and the monitor maximum reads 0x000.
- R2: A falling edge of `sample_i` copies `pos_acc_i` and `vel_acc_i` into the holding registers in the same clock cycle. Later changes on the integrator inputs do not alter what a read returns until the next falling edge. Angle is unsigned and speed is two's complement, and both pass through bit for bit.
- R3: Three clock cycles after `sample_i` rises, the minimum reads 0xFFF and the maximum reads 0x000.
- R4: Outside the clear cycle, the minimum and maximum are updated every clock cycle. Each one then holds the extreme of every `mon_mag_i` value presented since the last clear.
- R5: The select line is sampled at the read-strobe falling edge: 1 picks the angle and 0 picks the speed. Changing it while the read strobe stays low has no effect.
- R6: In parallel mode (`par_mode_i` = 1), all 12 enables are high only after a read-strobe fall with chip select low, and only while both stay low. All enables drop after either one returns high.
- R7: A read-strobe fall while chip select is high loads nothing and enables no pin.
- R8: In serial mode (`par_mode_i` = 0), only `bus_oe_o[11]` can be enabled. Bit 10 is the serial clock input and bits 0–9 are undriven. `bus_q_o[11]` shows the word MSB first: bit 11 appears at load, and each falling serial-clock edge advances one bit.
- R9: A read-strobe fall driven on a bus pin shows up on the enables exactly three clock edges later: two synchroniser stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample strobe: falling edge freezes the words, rising edge clears the extremes |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| pos_sel_i | input | 1 | 1 = angle, 0 = speed |
| par_mode_i | input | 1 | 1 = parallel bus, 0 = serial port |
| sclk_i | input | 1 | Serial clock (shares bus pin 10 in serial mode) |
| pos_acc_i | input | 12 | Angle integrator, unsigned |
| vel_acc_i | input | 12 | Speed integrator, two's complement |
| mon_mag_i | input | 12 | Monitor magnitude, sampled every cycle |
| bus_q_o | output | 12 | Bus pin output values |
| bus_oe_o | output | 12 | Per-pin output enable |
| mon_min_o | output | 12 | Smallest monitor magnitude since clear |
| mon_max_o | output | 12 | Largest monitor magnitude since clear |

## Verification
A sweep of angle/speed pairs covers zero, all ones, and both sign boundaries of the speed word, plus arithmetic progressions across the range. After every freeze the integrator inputs are driven to their complements. A read that leaks live data therefore differs in every bit from the expected frozen value. Every pair is read as angle and as speed, and a share of them also through the serial port bit by bit, which separates select errors from bit-order errors. Monitor sequences built from modular progressions compare the extremes with minima and maxima computed in the bench. A chip-select-high read and a cycle-exact check of enable timing cover the remaining control corners.

// File: rtl/rr_pkg.sv
package rr_pkg;
  parameter int RR_W = 12;
  // synchroniser bit positions
  localparam int SI_SMP = 0;
  localparam int SI_CS  = 1;
  localparam int SI_RD  = 2;
  localparam int SI_SEL = 3;
  localparam int SI_PAR = 4;
  localparam int SI_SCK = 5;
  localparam int SI_N   = 6;
  // idle levels of the host lines
  localparam logic [SI_N-1:0] SI_IDLE = 6'b110111;
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE[i];
        stab_q <= IDLE[i];
      end else begin
        meta_q <= async_i[i];
        stab_q <= meta_q;
      end
    end
    assign lvl_o[i] = stab_q;
  end
endmodule

// File: rtl/rr_edge.sv
module rr_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/rr_extrema.sv
module rr_extrema #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] mag_i,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_o <= '1;
      max_o <= '0;
    end else if (clr_i) begin
      min_o <= '1;
      max_o <= '0;
    end else begin
      if (mag_i < min_o) min_o <= mag_i;
      if (mag_i > max_o) max_o <= mag_i;
    end
  end
endmodule

// File: rtl/rr_outport.sv
module rr_outport #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         rd_fall_i,
  input  logic         sel_pos_i,
  input  logic         sck_fall_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] vel_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] oe_o,
  output logic         act_o
);
  localparam int SDO = W - 1;

  logic         act_q;
  logic [W-1:0] word_q;
  logic [W-1:0] shift_q;
  logic         load;
  logic [W-1:0] pick;

  assign load = rd_fall_i & ~cs_n_i;
  assign pick = sel_pos_i ? pos_i : vel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      word_q  <= '0;
      shift_q <= '0;
    end else if (load) begin
      act_q   <= 1'b1;
      word_q  <= pick;
      shift_q <= pick;
    end else if (cs_n_i || rd_n_i) begin
      act_q <= 1'b0;
    end else if (act_q && sck_fall_i) begin
      shift_q <= {shift_q[W-2:0], 1'b0};
    end
  end

  always_comb begin
    q_o  = '0;
    oe_o = '0;
    if (par_i) begin
      q_o  = word_q;
      oe_o = {W{act_q}};
    end else begin
      q_o[SDO]  = shift_q[W-1];
      oe_o[SDO] = act_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/resolver_readout.sv
module resolver_readout
  import rr_pkg::*;
#(
  parameter int W = RR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         pos_sel_i,
  input  logic         par_mode_i,
  input  logic         sclk_i,
  input  logic [W-1:0] pos_acc_i,
  input  logic [W-1:0] vel_acc_i,
  input  logic [W-1:0] mon_mag_i,
  output logic [W-1:0] bus_q_o,
  output logic [W-1:0] bus_oe_o,
  output logic [W-1:0] mon_min_o,
  output logic [W-1:0] mon_max_o
);
  logic [SI_N-1:0] raw, lvl;
  logic smp_rise, smp_fall, rd_rise, rd_fall, sck_rise, sck_fall;
  logic [W-1:0] pos_q, vel_q;
  logic rd_act;

  assign raw[SI_SMP] = sample_i;
  assign raw[SI_CS]  = cs_n_i;
  assign raw[SI_RD]  = rd_n_i;
  assign raw[SI_SEL] = pos_sel_i;
  assign raw[SI_PAR] = par_mode_i;
  assign raw[SI_SCK] = sclk_i;

  rr_sync #(.N(SI_N), .IDLE(SI_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .lvl_o(lvl)
  );

  rr_edge #(.IDLE(1'b1)) u_smp_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[SI_SMP]), .rise_o(smp_rise), .fall_o(smp_fall)
  );
  rr_edge #(.IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[SI_RD]), .rise_o(rd_rise), .fall_o(rd_fall)
  );
  rr_edge #(.IDLE(1'b1)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[SI_SCK]), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  wire unused_edges = rd_rise ^ sck_rise;

  // both words frozen on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else if (smp_fall) begin
      pos_q <= pos_acc_i;
      vel_q <= vel_acc_i;
    end
  end

  rr_extrema #(.W(W)) u_ext (
    .clk(clk), .rst_n(rst_n), .clr_i(smp_rise), .mag_i(mon_mag_i),
    .min_o(mon_min_o), .max_o(mon_max_o)
  );

  rr_outport #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .par_i(lvl[SI_PAR]), .cs_n_i(lvl[SI_CS]), .rd_n_i(lvl[SI_RD]),
    .rd_fall_i(rd_fall), .sel_pos_i(lvl[SI_SEL]), .sck_fall_i(sck_fall),
    .pos_i(pos_q), .vel_i(vel_q),
    .q_o(bus_q_o), .oe_o(bus_oe_o), .act_o(rd_act)
  );
endmodule

// File: rtl/rr_chk.sv
module rr_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_rise,
  input logic         smp_fall,
  input logic         cs_lvl,
  input logic         rd_lvl,
  input logic         par_lvl,
  input logic [W-1:0] pos_q,
  input logic [W-1:0] vel_q,
  input logic [W-1:0] oe,
  input logic [W-1:0] mn,
  input logic [W-1:0] mx
);
  // R2
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_fall) |-> ($stable(pos_q) && $stable(vel_q)));
  // R3
  extrema_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_rise) |-> (mn == '1 && mx == '0));
  // R4
  max_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_rise) |-> (mx >= $past(mx) && mn <= $past(mn)));
  // R6
  drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oe) |-> $past(!cs_lvl && !rd_lvl));
  // R8
  serial_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lvl |-> (oe[W-2:0] == '0));
endmodule

bind resolver_readout rr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_rise(smp_rise), .smp_fall(smp_fall),
  .cs_lvl(lvl[rr_pkg::SI_CS]), .rd_lvl(lvl[rr_pkg::SI_RD]), .par_lvl(lvl[rr_pkg::SI_PAR]),
  .pos_q(pos_q), .vel_q(vel_q), .oe(bus_oe_o), .mn(mon_min_o), .mx(mon_max_o)
);

// File: tb/tb_resolver_readout.sv
`timescale 1ns/1ps
module tb_resolver_readout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b1, cs_n_i = 1'b1, rd_n_i = 1'b1;
  logic pos_sel_i = 1'b0, par_mode_i = 1'b1, sclk_i = 1'b1;
  logic [11:0] pos_acc_i = '0, vel_acc_i = '0, mon_mag_i = '0;
  logic [11:0] bus_q_o, bus_oe_o, mon_min_o, mon_max_o;
  int nvec = 0, nerr = 0;

  always #10 clk = ~clk;

  resolver_readout dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_sample(input logic [11:0] p, input logic [11:0] v);
    pos_acc_i = p; vel_acc_i = v;
    sample_i = 1'b0; tick(4);
    pos_acc_i = ~p; vel_acc_i = ~v;   // integrators keep moving
    sample_i = 1'b1; tick(4);
  endtask

  task automatic par_read(input logic s, input logic [11:0] exp, input string req);
    par_mode_i = 1'b1; pos_sel_i = s; cs_n_i = 1'b0; tick(4);
    rd_n_i = 1'b0; tick(4);
    chk({req, " oe"}, bus_oe_o, 12'hFFF);
    chk(req, bus_q_o, exp);
    pos_sel_i = ~s; tick(4);
    chk("R5 select change ignored", bus_q_o, exp);
    rd_n_i = 1'b1; tick(4);
    chk("R6 release", bus_oe_o, 12'h000);
    cs_n_i = 1'b1; tick(2);
  endtask

  task automatic ser_read(input logic s, input logic [11:0] exp);
    par_mode_i = 1'b0; sclk_i = 1'b1; pos_sel_i = s; cs_n_i = 1'b0; tick(4);
    rd_n_i = 1'b0; tick(4);
    chk("R8 serial oe", bus_oe_o, 12'h800);
    chk("R8 bit11", {11'b0, bus_q_o[11]}, {11'b0, exp[11]});
    for (int i = 10; i >= 0; i--) begin
      sclk_i = 1'b0; tick(4);
      chk("R8 serial bit", {11'b0, bus_q_o[11]}, {11'b0, exp[i]});
      sclk_i = 1'b1; tick(4);
    end
    rd_n_i = 1'b1; cs_n_i = 1'b1; tick(4);
    chk("R8 serial release", bus_oe_o, 12'h000);
    par_mode_i = 1'b1; tick(4);
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 oe", bus_oe_o, 12'h000);
    chk("R1 min", mon_min_o, 12'hFFF);
    chk("R1 max", mon_max_o, 12'h000);
    rst_n = 1'b1; tick(4);

    // R9 exact latency
    do_sample(12'h5A5, 12'h3C3);
    cs_n_i = 1'b0; pos_sel_i = 1'b1; tick(4);
    rd_n_i = 1'b0; tick(2);
    chk("R9 not yet", bus_oe_o, 12'h000);
    tick(1);
    chk("R9 on third edge", bus_oe_o, 12'hFFF);
    chk("R9 data", bus_q_o, 12'h5A5);
    rd_n_i = 1'b1; cs_n_i = 1'b1; tick(4);

    // R7 chip select high
    cs_n_i = 1'b1; rd_n_i = 1'b0; tick(5);
    chk("R7 no drive", bus_oe_o, 12'h000);
    rd_n_i = 1'b1; tick(4);

    // R2 R5 R6 R8 sweep
    for (int k = 0; k < 68; k++) begin
      logic [11:0] p, v;
      case (k)
        64: begin p = 12'h000; v = 12'h800; end
        65: begin p = 12'hFFF; v = 12'h7FF; end
        66: begin p = 12'h800; v = 12'hFFF; end
        67: begin p = 12'h7FF; v = 12'h000; end
        default: begin p = 12'((k * 67 + 5) % 4096); v = 12'((k * 1013 + 2048) % 4096); end
      endcase
      do_sample(p, v);
      par_read(1'b1, p, "R2 angle");
      par_read(1'b0, v, "R2 speed");
      if (k % 4 == 0) begin
        ser_read(1'b1, p);
        ser_read(1'b0, v);
      end
    end

    // R3 R4 monitor extremes
    for (int t = 0; t < 8; t++) begin
      logic [11:0] vals [8];
      logic [11:0] emin, emax;
      for (int i = 0; i < 8; i++) vals[i] = 12'((t * 37 + i * 101 + t * i * 53) % 4096);
      emin = 12'hFFF; emax = 12'h000;
      for (int i = 0; i < 8; i++) begin
        if (vals[i] < emin) emin = vals[i];
        if (vals[i] > emax) emax = vals[i];
      end
      sample_i = 1'b0; mon_mag_i = 12'hFFF; tick(4);
      mon_mag_i = vals[0];
      sample_i = 1'b1; tick(3);
      chk("R3 min cleared", mon_min_o, 12'hFFF);
      chk("R3 max cleared", mon_max_o, 12'h000);
      for (int i = 1; i < 8; i++) begin
        tick(1);
        mon_mag_i = vals[i];
      end
      tick(2);
      chk("R4 min", mon_min_o, emin);
      chk("R4 max", mon_max_o, emax);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule